// File: doc/BRIEF.md
# Per-Word Decrypt and Integrity Checker

This block is the fast read path for a protected cache line. Ciphertext comes back from external memory one 32-bit beat at a time, and each beat carries its own word index. Each beat is XORed with its slice of a 256-bit pad that has already been generated. The result is then checked against an 8-bit CRC tag kept for that word, so each word is released with its own integrity verdict and the block never waits for the rest of the line. Beats may arrive back-to-back, with idle gaps between them, and in any index order. Words that follow one another overlap in a three-stage pipeline.

The whole line is summarised too. One cycle after the last word of a line leaves the pipeline, a done pulse is raised. Alongside it sits a sticky flag that ORs together every word error of that line. A second path has no clock and serves writes. It turns a 256-bit plaintext line into the eight tags that must be stored with it, and it does this before the line is encrypted.

The pad and the tag vector are expected to stay stable while their line's beats are in flight.

Top module: `word_decrypt_guard`

## Requirements
- R1: While reset is held and after it is released, with no beats presented, `word_valid_o`, `word_err_o`, `line_done_o` and `line_err_o` are all 0.
- R2: For a beat with index i, the released word is the beat's ciphertext XOR `pad_i[32*i+31:32*i]`, and `word_idx_o` echoes i.
- R3: A beat accepted in cycle c (with `beat_valid_i` high) appears on `word_valid_o` in cycle c+3 and in no other cycle. Beats in consecutive cycles produce outputs in consecutive cycles.
- R4: The check value is a CRC over the 32-bit plaintext word. The polynomial is x^8+x^2+x+1 (0x07), the initial value is zero, there is no reflection and no final XOR, and bits are processed from bit 31 down to bit 0. `word_err_o` is 1 exactly when this CRC differs from `tag_i[8*i+7:8*i]`.
- R5: Idle cycles between beats produce no output word, and beats may carry their indices in any order.
- R6: `line_done_o` is a single-cycle pulse. It appears in the cycle after every eighth word leaves the pipeline, counted from reset.
- R7: `line_err_o` is updated in the cycle after each output word. It holds the OR of the error flags of the line's words seen so far, including the last word's flag when `line_done_o` is high. It restarts from the first word of the next line.
- R8: `wr_tag_o[8*i+7:8*i]` equals the R4 CRC of `wr_pt_i[32*i+31:32*i]` for every word i, and settles combinationally.
- R9: `word_err_o` is 0 in every cycle in which `word_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_i | input | 256 | Keystream pad of the line being read |
| tag_i | input | 64 | Stored CRC tags of the line, 8 bits per word |
| beat_valid_i | input | 1 | A ciphertext beat is present |
| beat_idx_i | input | 3 | Word position of the beat within the line |
| beat_ct_i | input | 32 | Ciphertext word |
| word_valid_o | output | 1 | A decrypted word is present |
| word_idx_o | output | 3 | Word position of the released word |
| word_pt_o | output | 32 | Decrypted word |
| word_err_o | output | 1 | Integrity mismatch on the released word |
| line_done_o | output | 1 | Pulse after the eighth word of a line |
| line_err_o | output | 1 | Sticky OR of the line's word errors |
| wr_pt_i | input | 256 | Plaintext line on the write side |
| wr_tag_o | output | 64 | Tags computed for the write line |

## Verification
The bench builds the block with its default parameters: eight 32-bit words per line, 8-bit tags and polynomial 0x07. This makes the top slice (index 7) and the full 3-bit index range reachable, as does the wrap of the line counter from 7 back to 0 across several consecutive lines. A lone corrupted ciphertext beat and a lone wrong tag each show that a single bad word raises both its own flag and the line flag. A clean line that follows shows that the line flag clears again. The reversed and gapped beat orders show that pad selection follows the carried index rather than arrival order.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Index width for a count of items, never below one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/wdg_crc.sv
// Combinational CRC over one data word, MSB first, zero start value.
module wdg_crc #(
   parameter int unsigned         DATA_W = 32,
   parameter int unsigned         CRC_W  = 8,
   parameter logic [CRC_W-1:0]    POLY   = 'h07
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);

   if (CRC_W < 2 || CRC_W > DATA_W) begin : g_bad_width
      $error("wdg_crc: CRC_W must lie in 2..DATA_W");
   end

   always_comb begin
      logic [CRC_W-1:0] rem;
      rem = '0;
      for (int b = DATA_W - 1; b >= 0; b--) begin
         if (rem[CRC_W-1] ^ data_i[b]) rem = (rem << 1) ^ POLY;
         else                          rem = rem << 1;
      end
      crc_o = rem;
   end

endmodule

// File: rtl/wdg_read_pipe.sv
// Three register stages: capture+select, unmask, check.
module wdg_read_pipe import wdg_pkg::*; #(
   parameter int unsigned      WORD_W = 32,
   parameter int unsigned      WORDS  = 8,
   parameter int unsigned      CRC_W  = 8,
   parameter logic [CRC_W-1:0] POLY   = 'h07,
   localparam int unsigned     IDX_W  = idx_bits(WORDS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WORD_W*WORDS-1:0]  pad_i,
   input  logic [CRC_W*WORDS-1:0]   tag_i,
   input  logic                     beat_valid_i,
   input  logic [IDX_W-1:0]         beat_idx_i,
   input  logic [WORD_W-1:0]        beat_ct_i,
   output logic                     word_valid_o,
   output logic [IDX_W-1:0]         word_idx_o,
   output logic [WORD_W-1:0]        word_pt_o,
   output logic                     word_err_o
);

   logic [WORD_W-1:0] pad_sl [WORDS];
   logic [CRC_W-1:0]  tag_sl [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_slice
      assign pad_sl[g] = pad_i[g*WORD_W +: WORD_W];
      assign tag_sl[g] = tag_i[g*CRC_W  +: CRC_W];
   end

   // Stage 1: beat captured with its own pad and tag slice
   logic              s1_v;
   logic [IDX_W-1:0]  s1_idx;
   logic [WORD_W-1:0] s1_ct, s1_pad;
   logic [CRC_W-1:0]  s1_tag;
   // Stage 2: plaintext
   logic              s2_v;
   logic [IDX_W-1:0]  s2_idx;
   logic [WORD_W-1:0] s2_pt;
   logic [CRC_W-1:0]  s2_tag;
   logic [CRC_W-1:0]  s2_crc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v         <= 1'b0;
         s2_v         <= 1'b0;
         word_valid_o <= 1'b0;
         word_err_o   <= 1'b0;
      end else begin
         s1_v         <= beat_valid_i;
         s2_v         <= s1_v;
         word_valid_o <= s2_v;
         word_err_o   <= s2_v && (s2_crc != s2_tag);
      end
   end

   always_ff @(posedge clk) begin
      s1_idx     <= beat_idx_i;
      s1_ct      <= beat_ct_i;
      s1_pad     <= pad_sl[beat_idx_i];
      s1_tag     <= tag_sl[beat_idx_i];
      s2_idx     <= s1_idx;
      s2_pt      <= s1_ct ^ s1_pad;
      s2_tag     <= s1_tag;
      word_idx_o <= s2_idx;
      word_pt_o  <= s2_pt;
   end

   wdg_crc #(.DATA_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) i_chk_crc (
      .data_i (s2_pt),
      .crc_o  (s2_crc)
   );

endmodule

// File: rtl/wdg_line_track.sv
// Counts released words, pulses at each line end, keeps sticky line error.
module wdg_line_track import wdg_pkg::*; #(
   parameter int unsigned  WORDS = 8,
   localparam int unsigned IDX_W = idx_bits(WORDS),
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic word_valid_i,
   input  logic word_err_i,
   output logic line_done_o,
   output logic line_err_o
);

   logic [IDX_W-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q      <= '0;
         line_done_o <= 1'b0;
         line_err_o  <= 1'b0;
      end else begin
         line_done_o <= word_valid_i && (seen_q == LAST);
         if (word_valid_i) begin
            seen_q     <= (seen_q == LAST) ? '0 : seen_q + 1'b1;
            line_err_o <= (seen_q == '0) ? word_err_i : (line_err_o | word_err_i);
         end
      end
   end

endmodule

// File: rtl/word_decrypt_guard.sv
module word_decrypt_guard import wdg_pkg::*; #(
   parameter int unsigned      WORD_W = 32,
   parameter int unsigned      WORDS  = 8,
   parameter int unsigned      CRC_W  = 8,
   parameter logic [CRC_W-1:0] POLY   = 'h07,
   localparam int unsigned     IDX_W  = idx_bits(WORDS),
   localparam int unsigned     LINE_W = WORD_W * WORDS,
   localparam int unsigned     TAG_W  = CRC_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] pad_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic              beat_valid_i,
   input  logic [IDX_W-1:0]  beat_idx_i,
   input  logic [WORD_W-1:0] beat_ct_i,
   output logic              word_valid_o,
   output logic [IDX_W-1:0]  word_idx_o,
   output logic [WORD_W-1:0] word_pt_o,
   output logic              word_err_o,
   output logic              line_done_o,
   output logic              line_err_o,
   input  logic [LINE_W-1:0] wr_pt_i,
   output logic [TAG_W-1:0]  wr_tag_o
);

   if (!is_pow2(WORDS) || WORDS < 2) begin : g_bad_words
      $error("word_decrypt_guard: WORDS must be a power of two, at least 2");
   end
   if (WORD_W < 8) begin : g_bad_word_w
      $error("word_decrypt_guard: WORD_W must be at least 8");
   end

   wdg_read_pipe #(
      .WORD_W (WORD_W), .WORDS (WORDS), .CRC_W (CRC_W), .POLY (POLY)
   ) i_read_pipe (
      .clk          (clk),
      .rst_n        (rst_n),
      .pad_i        (pad_i),
      .tag_i        (tag_i),
      .beat_valid_i (beat_valid_i),
      .beat_idx_i   (beat_idx_i),
      .beat_ct_i    (beat_ct_i),
      .word_valid_o (word_valid_o),
      .word_idx_o   (word_idx_o),
      .word_pt_o    (word_pt_o),
      .word_err_o   (word_err_o)
   );

   wdg_line_track #(.WORDS (WORDS)) i_line_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_valid_i (word_valid_o),
      .word_err_i   (word_err_o),
      .line_done_o  (line_done_o),
      .line_err_o   (line_err_o)
   );

   // Write side: one CRC unit per word, purely combinational
   for (genvar w = 0; w < WORDS; w++) begin : g_wr_tag
      wdg_crc #(.DATA_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) i_wr_crc (
         .data_i (wr_pt_i[w*WORD_W +: WORD_W]),
         .crc_o  (wr_tag_o[w*CRC_W +: CRC_W])
      );
   end

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker import wdg_pkg::*; #(
   parameter int unsigned  WORD_W = 32,
   parameter int unsigned  WORDS  = 8,
   localparam int unsigned IDX_W  = idx_bits(WORDS),
   localparam int unsigned LINE_W = WORD_W * WORDS
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LINE_W-1:0] pad_i,
   input logic              beat_valid_i,
   input logic [IDX_W-1:0]  beat_idx_i,
   input logic [WORD_W-1:0] beat_ct_i,
   input logic              word_valid_o,
   input logic [IDX_W-1:0]  word_idx_o,
   input logic [WORD_W-1:0] word_pt_o,
   input logic              word_err_o,
   input logic              line_done_o,
   input logic              line_err_o
);

   // Edges seen since reset release, saturating at 3
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3) |-> (word_valid_o == $past(beat_valid_i, 3)));

   assert_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && word_valid_o) |-> (word_idx_o == $past(beat_idx_i, 3)));

   assert_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && word_valid_o) |->
      (word_pt_o == ($past(beat_ct_i, 3) ^
                     WORD_W'($past(pad_i, 3) >> (WORD_W * $past(beat_idx_i, 3))))));

   assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid_o |-> !word_err_o);

   assert_done_after_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0 && line_done_o) |-> $past(word_valid_o));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      line_done_o |=> !line_done_o);

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && word_err_o) |=> line_err_o);

endmodule

bind word_decrypt_guard wdg_checker #(.WORD_W(WORD_W), .WORDS(WORDS)) i_wdg_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .pad_i        (pad_i),
   .beat_valid_i (beat_valid_i),
   .beat_idx_i   (beat_idx_i),
   .beat_ct_i    (beat_ct_i),
   .word_valid_o (word_valid_o),
   .word_idx_o   (word_idx_o),
   .word_pt_o    (word_pt_o),
   .word_err_o   (word_err_o),
   .line_done_o  (line_done_o),
   .line_err_o   (line_err_o)
);

// File: tb/test_word_decrypt_guard.sv
`timescale 1ns/1ps
module test_word_decrypt_guard;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [255:0]  pad_i = '0;
   logic [63:0]   tag_i = '0;
   logic          beat_valid_i = 1'b0;
   logic [2:0]    beat_idx_i = '0;
   logic [31:0]   beat_ct_i = '0;
   logic          word_valid_o;
   logic [2:0]    word_idx_o;
   logic [31:0]   word_pt_o;
   logic          word_err_o;
   logic          line_done_o;
   logic          line_err_o;
   logic [255:0]  wr_pt_i = '0;
   logic [63:0]   wr_tag_o;

   always #10 clk = ~clk;   // 50 MHz

   word_decrypt_guard i_word_decrypt_guard (
      .clk (clk), .rst_n (rst_n), .pad_i (pad_i), .tag_i (tag_i),
      .beat_valid_i (beat_valid_i), .beat_idx_i (beat_idx_i), .beat_ct_i (beat_ct_i),
      .word_valid_o (word_valid_o), .word_idx_o (word_idx_o), .word_pt_o (word_pt_o),
      .word_err_o (word_err_o), .line_done_o (line_done_o), .line_err_o (line_err_o),
      .wr_pt_i (wr_pt_i), .wr_tag_o (wr_tag_o)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // Bench model: three-entry history of driven beats
   logic        hv [3];
   logic [2:0]  hi [3];
   logic [31:0] hp [3];
   logic        he [3];
   int          m_cnt = 0;
   logic        m_acc = 1'b0;
   logic        m_done = 1'b0;
   logic [31:0] plain [8];

   // Remainder of polynomial division by 0x107 (R4)
   function automatic logic [7:0] ref_crc(input logic [31:0] d);
      logic [39:0] r;
      r = {d, 8'h00};
      for (int i = 39; i >= 8; i--)
         if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
      return r[7:0];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // One cycle: compare outputs with the beat driven three steps ago, then drive.
   task automatic step(input logic v, input int idx, input logic [31:0] ct);
      logic [31:0] pt;
      logic        err;
      @(negedge clk);
      chk(word_valid_o === hv[2], "R3/R5 word_valid", 64'(word_valid_o), 64'(hv[2]));
      if (hv[2]) begin
         chk(word_pt_o === hp[2], "R2 plaintext", 64'(word_pt_o), 64'(hp[2]));
         chk(word_idx_o === hi[2], "R2 index", 64'(word_idx_o), 64'(hi[2]));
         chk(word_err_o === he[2], "R4 word error", 64'(word_err_o), 64'(he[2]));
      end else begin
         chk(word_err_o === 1'b0, "R9 error while idle", 64'(word_err_o), 64'd0);
      end
      chk(line_done_o === m_done, "R6 line done", 64'(line_done_o), 64'(m_done));
      chk(line_err_o === m_acc, "R7 line error", 64'(line_err_o), 64'(m_acc));
      if (hv[2]) begin
         m_acc  = (m_cnt == 0) ? he[2] : (m_acc | he[2]);
         m_done = (m_cnt == 7);
         m_cnt  = (m_cnt + 1) % 8;
      end else begin
         m_done = 1'b0;
      end
      for (int k = 2; k > 0; k--) begin
         hv[k] = hv[k-1]; hi[k] = hi[k-1]; hp[k] = hp[k-1]; he[k] = he[k-1];
      end
      pt  = ct ^ pad_i[idx*32 +: 32];
      err = (ref_crc(pt) != tag_i[idx*8 +: 8]);
      hv[0] = v; hi[0] = 3'(idx); hp[0] = pt; he[0] = err;
      beat_valid_i = v;
      beat_idx_i   = 3'(idx);
      beat_ct_i    = v ? ct : 32'hDEAD_BEEF;
   endtask

   task automatic flush();
      for (int k = 0; k < 5; k++) step(1'b0, 0, 32'h0);
   endtask

   // Fresh pad, plaintext and matching tags for a line
   task automatic load_line(input logic [31:0] seed);
      for (int w = 0; w < 8; w++) begin
         pad_i[w*32 +: 32] = (32'h9E37_79B9 * (w + 1)) ^ seed;
         plain[w]          = (seed * (w + 3)) ^ (32'h0101_0101 << w);
         tag_i[w*8 +: 8]   = ref_crc(plain[w]);
      end
   endtask

   function automatic logic [31:0] cipher(input int w);
      return plain[w] ^ pad_i[w*32 +: 32];
   endfunction

   task automatic test_reset();
      rst_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(word_valid_o === 1'b0, "R1 valid in reset", 64'(word_valid_o), 64'd0);
         chk(line_done_o === 1'b0, "R1 done in reset", 64'(line_done_o), 64'd0);
         chk(line_err_o === 1'b0, "R1 line error in reset", 64'(line_err_o), 64'd0);
         chk(word_err_o === 1'b0, "R1 word error in reset", 64'(word_err_o), 64'd0);
      end
      for (int k = 0; k < 3; k++) begin
         hv[k] = 1'b0; hi[k] = '0; hp[k] = '0; he[k] = 1'b0;
      end
      m_cnt = 0; m_acc = 1'b0; m_done = 1'b0;
      rst_n = 1'b1;
      flush();
   endtask

   // Back-to-back beats in index order, all clean (R2, R3, R6)
   task automatic test_clean_burst();
      load_line(32'h1234_5678);
      for (int w = 0; w < 8; w++) step(1'b1, w, cipher(w));
      flush();
   endtask

   // Gapped beats, reversed order, one corrupted ciphertext (R4, R5, R7)
   task automatic test_gapped_corrupt();
      load_line(32'hA5A5_0F0F);
      for (int w = 7; w >= 0; w--) begin
         step(1'b1, w, (w == 5) ? (cipher(w) ^ 32'h0000_0100) : cipher(w));
         if (w % 2 == 0) step(1'b0, 0, 32'h0);
         if (w == 3) begin
            step(1'b0, 0, 32'h0);
            step(1'b0, 0, 32'h0);
         end
      end
      flush();
   endtask

   // Clean line after an erroring one: line error must restart (R7)
   task automatic test_clear_after_error();
      load_line(32'h0BAD_F00D);
      for (int w = 0; w < 8; w++) step(1'b1, (w * 3) % 8, cipher((w * 3) % 8));
      flush();
   endtask

   // Wrong stored tag on the top word (R4, R7)
   task automatic test_bad_tag();
      load_line(32'h7777_1111);
      tag_i[7*8 +: 8] = tag_i[7*8 +: 8] ^ 8'h01;
      for (int w = 0; w < 8; w++) step(1'b1, w, cipher(w));
      flush();
      load_line(32'h0000_0000);
      for (int w = 0; w < 8; w++) step(1'b1, w, cipher(w));
      flush();
   endtask

   // Write-side tags (R8)
   task automatic test_write_tags();
      logic [255:0] pats [3];
      pats[0] = '0;
      pats[1] = {8{32'h8000_0001}};
      for (int w = 0; w < 8; w++) pats[2][w*32 +: 32] = 32'hC3D2_E1F0 * (w + 7);
      for (int p = 0; p < 3; p++) begin
         @(negedge clk);
         wr_pt_i = pats[p];
         #1;
         for (int w = 0; w < 8; w++)
            chk(wr_tag_o[w*8 +: 8] === ref_crc(wr_pt_i[w*32 +: 32]), "R8 write tag",
                64'(wr_tag_o[w*8 +: 8]), 64'(ref_crc(wr_pt_i[w*32 +: 32])));
      end
   endtask

   initial begin
      test_reset();
      test_clean_burst();
      test_gapped_corrupt();
      test_clear_after_error();
      test_bad_tag();
      test_write_tags();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule